// File: doc/BRIEF.md
# Modulus Down-Counter with Load Register

This block is a 16-bit down-counter that decrements once per prescaled tick while enabled. A load register holds the reload value. In periodic mode the counter reloads from it each time a decrement takes it from 1 to 0. In one-shot mode the counter runs down to zero and then stays there. A sticky zero flag marks each underflow or run-out.

The host writes and reads a word through a single-cycle bus. Where a write lands depends on the mode:
- With the counter enabled in periodic mode, a write is deferred. Only the load register takes it, and the count picks it up at the next underflow.
- In every other case, the write loads the count at once and restarts the prescaler.

A force-load strobe copies the load register into the count without waiting. A zero write parks the counter without raising the flag. If the two latch configuration inputs are both high, a zero write also sends a one-cycle latch request to the neighbouring capture logic.

Top module: `modulus_downcounter`

## Requirements
- R1: After reset, the count and the load register both hold 0xFFFF, and the zero flag and the latch request are 0.
- R2: While rd_en is 1, rd_data shows the live count when rd_load_sel is 0 and the load register when rd_load_sel is 1, in the same cycle. While rd_en is 0, rd_data is 0.
- R3: A write made while cnt_en and periodic_mode are both 1 goes to the load register only. The count keeps decrementing from its old value and takes the written value at the next underflow.
- R4: A write made while cnt_en or periodic_mode is 0 loads the count on the next edge and restarts the prescaler. The first decrement then comes a full prescale period later. The load register takes the written value too.
- R5: presc_sel values 0, 1, 2 and 3 give one decrement every 1, 4, 8 and 16 clock cycles. With cnt_en at 0, neither the count nor the prescaler moves.
- R6: In periodic mode, a decrement from 1 reloads the count from the load register and sets the zero flag.
- R7: In one-shot mode, a decrement from 1 to 0 sets the zero flag. The count then holds at 0 until it is written or force-loaded.
- R8: A force_load pulse copies the load register into the count on the next edge. An immediate write in the same cycle takes precedence over it.
- R9: Writing 0x0000 leaves the count at 0, and this never sets the zero flag.
- R10: A write of 0x0000 while latch_en and buf_en are both 1 gives a latch_req pulse one cycle long, on the cycle after the write. Other writes give no pulse.
- R11: The zero flag stays set until a zflag_clr cycle clears it. If a set and a clear occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| periodic_mode | input | 1 | 1 = reload on underflow, 0 = one-shot |
| rd_load_sel | input | 1 | Read source: 0 = count, 1 = load register |
| force_load | input | 1 | Copy the load register into the count |
| presc_sel | input | 2 | Prescale select: divide by 1, 4, 8 or 16 |
| latch_en | input | 1 | Latch configuration input |
| buf_en | input | 1 | Buffer configuration input |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data |
| zflag_clr | input | 1 | Write-one-to-clear for the zero flag |
| zero_flag | output | 1 | Sticky zero/underflow flag |
| latch_req | output | 1 | One-cycle latch request |

## Verification
The assertions check the following on every cycle:
- the write routing: a deferred write leaves the count alone between ticks, and an immediate write lands on the next edge;
- the one-shot hold at zero;
- the zero-write rule;
- set-over-clear priority on the flag;
- the cause of every latch pulse;
- the rule that the count moves only on a tick, a write or a force.

Only the bench's scenarios can show the following, because it compares the block against a reference model over whole runs:
- the exact prescale periods;
- the reload value chosen after a deferred write;
- the read multiplexing;
- the reset contents.

// File: rtl/mdc_pkg.sv
// Package: shared widths and the prescale-divisor helper for the
// modulus down-counter. Assumes the prescaler select is at most a few bits.
package mdc_pkg;
    localparam int CNT_W_DEF = 16;
    localparam int SEL_W_DEF = 2;

    // Terminal prescaler value for a select code: 0 -> 0, n -> 2^(n+1)-1.
    function automatic int div_last(input int sel);
        if (sel == 0) return 0;
        return (1 << (sel + 1)) - 1;
    endfunction
endpackage

// File: rtl/mdc_prescaler.sv
// Module: prescaler. It emits one tick every 1, 4, 8 or 16 enabled cycles.
// Assumes restart has priority, and that the phase counter holds while run is low.
module mdc_prescaler #(
    parameter int SEL_W = 2,
    localparam int PCNT_W = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] last;

    // Purpose: decode the terminal phase from the select code.
    always_comb last = PCNT_W'(mdc_pkg::div_last(int'(sel)));

    // Purpose: flag the terminal phase while running.
    always_comb tick = run && (pcnt == last);

    // Purpose: advance the phase counter; a restart returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       pcnt <= '0;
        else if (restart) pcnt <= '0;
        else if (run)     pcnt <= tick ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/mdc_count_core.sv
// Module: count and load registers. It applies immediate writes, force
// loads, decrements and periodic reloads, in that order of priority.
// Assumes tick occurs only while the counter is enabled.
module mdc_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         periodic,
    input  logic         imm_wr,
    input  logic         force_load,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_q,
    output logic [W-1:0] load_q,
    output logic         zflag_set
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ONES = '1;

    logic at_one;

    // Purpose: detect the last decrement before zero.
    always_comb at_one = (count_q == ONE);

    // Purpose: a flag event occurs when a counting tick leaves the value 1.
    always_comb zflag_set = !imm_wr && !force_load && tick && at_one;

    // Purpose: the load register takes every bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)     load_q <= ONES;
        else if (wr_en) load_q <= wr_data;
    end

    // Purpose: update the count by priority: write, force, count.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count_q <= ONES;
        else if (imm_wr)                  count_q <= wr_data;
        else if (force_load)              count_q <= load_q;
        else if (tick && at_one)          count_q <= periodic ? load_q : '0;
        else if (tick && count_q != '0)   count_q <= count_q - ONE;
    end
endmodule

// File: rtl/modulus_downcounter.sv
// Module: top of the modulus down-counter. It routes writes to a deferred
// or an immediate load, keeps the sticky zero flag, drives the latch
// request and the read port.
// Assumes single-cycle word access and a synchronous active-low reset.
module modulus_downcounter #(
    parameter int CNT_W = mdc_pkg::CNT_W_DEF,
    parameter int SEL_W = mdc_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             periodic_mode,
    input  logic             rd_load_sel,
    input  logic             force_load,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             latch_en,
    input  logic             buf_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    input  logic             zflag_clr,
    output logic             zero_flag,
    output logic             latch_req
);
    logic             imm_wr;
    logic             tick;
    logic             zflag_set;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_q;

    // Purpose: a write is deferred only when enabled in periodic mode.
    always_comb imm_wr = wr_en && !(cnt_en && periodic_mode);

    mdc_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cnt_en),
        .restart (imm_wr),
        .sel     (presc_sel),
        .tick    (tick)
    );

    mdc_count_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .periodic   (periodic_mode),
        .imm_wr     (imm_wr),
        .force_load (force_load),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .count_q    (count_q),
        .load_q     (load_q),
        .zflag_set  (zflag_set)
    );

    // Purpose: sticky zero flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         zero_flag <= 1'b0;
        else if (zflag_set) zero_flag <= 1'b1;
        else if (zflag_clr) zero_flag <= 1'b0;
    end

    // Purpose: one-cycle latch request after a zero write with both enables.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_req <= 1'b0;
        else        latch_req <= wr_en && (wr_data == '0) && latch_en && buf_en;
    end

    // Purpose: single-cycle read of the count or the load register.
    always_comb begin
        if (!rd_en)           rd_data = '0;
        else if (rd_load_sel) rd_data = load_q;
        else                  rd_data = count_q;
    end
endmodule

// File: rtl/mdc_checker.sv
// Module: assertion checker for modulus_downcounter, attached by bind.
// Assumes the internal count, tick and flag-event nets are visible.
module mdc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         periodic_mode,
    input logic         force_load,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         latch_en,
    input logic         buf_en,
    input logic         zero_flag,
    input logic         latch_req,
    input logic [W-1:0] count_q,
    input logic         tick,
    input logic         zflag_set
);
    // R3: a deferred write with no tick leaves the count unchanged.
    a_r3_deferred_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cnt_en && periodic_mode && !force_load && !tick) |=> $stable(count_q));

    // R4: an immediate write lands in the count on the next edge.
    a_r4_immediate_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(cnt_en && periodic_mode)) |=> (count_q == $past(wr_data)));

    // R5: without a tick, write or force, the count does not move.
    a_r5_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !force_load && !tick) |=> $stable(count_q));

    // R7: in one-shot mode, a zero count holds when left alone.
    a_r7_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic_mode && count_q == '0 && !wr_en && !force_load) |=> (count_q == '0));

    // R9: an immediate zero write parks the count and raises no flag.
    a_r9_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0 && !(cnt_en && periodic_mode)) |=> (count_q == '0 && !$rose(zero_flag)));

    // R10: every latch pulse follows a qualified zero write.
    a_r10_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |-> $past(wr_en && wr_data == '0 && latch_en && buf_en));

    // R11: a flag event always leaves the flag set.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        zflag_set |=> zero_flag);
endmodule

bind modulus_downcounter mdc_checker #(.W(CNT_W)) u_mdc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_en        (cnt_en),
    .periodic_mode (periodic_mode),
    .force_load    (force_load),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .latch_en      (latch_en),
    .buf_en        (buf_en),
    .zero_flag     (zero_flag),
    .latch_req     (latch_req),
    .count_q       (count_q),
    .tick          (tick),
    .zflag_set     (zflag_set)
);

// File: tb/modulus_downcounter_bench.sv
// Bench: a behavioural reference model runs on every clock, and the block's
// outputs are compared with it at each falling edge.
module modulus_downcounter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, periodic_mode = 1'b0, rd_load_sel = 1'b0, force_load = 1'b0;
    logic [1:0]  presc_sel = 2'd0;
    logic        latch_en = 1'b0, buf_en = 1'b0, wr_en = 1'b0, rd_en = 1'b1, zflag_clr = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        zero_flag, latch_req;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_count = 16'hFFFF, m_load = 16'hFFFF, m_p = 0;
    bit m_flag = 0, m_latch = 0;

    always #10 clk = ~clk;

    modulus_downcounter u_modulus_downcounter (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .periodic_mode(periodic_mode),
        .rd_load_sel(rd_load_sel), .force_load(force_load), .presc_sel(presc_sel),
        .latch_en(latch_en), .buf_en(buf_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .zflag_clr(zflag_clr),
        .zero_flag(zero_flag), .latch_req(latch_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advance one clock from the inputs seen at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 16'hFFFF; m_load = 16'hFFFF; m_p = 0; m_flag = 0; m_latch = 0;
        end else begin
            int  last;
            bit  imm, tk, set;
            last = (presc_sel == 0) ? 0 : (1 << (presc_sel + 1)) - 1;
            imm  = wr_en && !(cnt_en && periodic_mode);
            tk   = cnt_en && (m_p == last);
            set  = 0;
            m_latch = wr_en && (wr_data == 0) && latch_en && buf_en;
            if (imm) begin
                m_count = wr_data;
            end else if (force_load) begin
                m_count = m_load;
            end else if (tk && m_count != 0) begin
                if (m_count == 1) begin
                    set = 1;
                    m_count = periodic_mode ? m_load : 0;
                end else begin
                    m_count = m_count - 1;
                end
            end
            if (imm)         m_p = 0;
            else if (cnt_en) m_p = tk ? 0 : (m_p + 1) % 16;
            if (wr_en) m_load = wr_data;
            if (set)            m_flag = 1;
            else if (zflag_clr) m_flag = 0;
        end
    end

    // Compare the block with the model mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, rd_data, rd_en ? (rd_load_sel ? m_load : m_count) : 0);
            check(cur_req, zero_flag, m_flag);
            check(cur_req, latch_req, m_latch);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            wr_en = 0; force_load = 0; zflag_clr = 0;
        end
    endtask

    task automatic bus_write(input logic [15:0] v);
        @(posedge clk); #2;
        wr_en = 1; wr_data = v; force_load = 0; zflag_clr = 0;
        step(1);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset contents
        #8;
        rd_load_sel = 0; #1 check("R1", rd_data, 16'hFFFF);
        rd_load_sel = 1; #1 check("R1", rd_data, 16'hFFFF);
        check("R1", zero_flag, 0); check("R1", latch_req, 0);
        rd_en = 0; #1 check("R2", rd_data, 0);
        rd_en = 1; rd_load_sel = 0;

        // R4 / R5 / R7: one-shot, divide by 4
        cur_req = "R4"; cnt_en = 1; periodic_mode = 0; presc_sel = 2'd1;
        bus_write(16'd5);
        cur_req = "R5"; step(12);
        cur_req = "R7"; rd_load_sel = 1; step(4); rd_load_sel = 0; step(20);
        #8 check("R7", rd_data, 0); check("R7", zero_flag, 1);

        // R11: clear held through a coincident set
        cur_req = "R11"; presc_sel = 2'd0;
        @(posedge clk); #2 zflag_clr = 1;
        @(posedge clk); #2 wr_en = 1; wr_data = 16'd3; zflag_clr = 1;
        for (int i = 0; i < 6; i++) begin @(posedge clk); #2 wr_en = 0; zflag_clr = 1; end
        zflag_clr = 0; step(3);

        // R8: force-load, then write beating force
        cur_req = "R8"; cnt_en = 0; periodic_mode = 1;
        bus_write(16'd4);
        @(posedge clk); #2 force_load = 1;
        step(2);
        #8 check("R8", rd_data, 4);
        @(posedge clk); #2 force_load = 1; wr_en = 1; wr_data = 16'd9;
        step(2);

        // R6 / R3: periodic run, deferred write
        cur_req = "R6"; cnt_en = 1; presc_sel = 2'd0;
        bus_write(16'd4);
        @(posedge clk); #2 force_load = 1;
        step(12);
        cur_req = "R3"; bus_write(16'd7);
        step(20);
        #8 check("R3", zero_flag, 1);

        // R5: divide by 8 and 16, with pauses
        cur_req = "R5"; periodic_mode = 0; presc_sel = 2'd2;
        bus_write(16'd3);
        step(10); cnt_en = 0; step(10); cnt_en = 1; step(20);
        presc_sel = 2'd3; bus_write(16'd2); step(40);

        // R9 / R10: zero writes with and without the latch enables
        cur_req = "R9"; @(posedge clk); #2 zflag_clr = 1; step(1);
        latch_en = 1; buf_en = 1; presc_sel = 2'd0;
        cur_req = "R10"; bus_write(16'd0);
        step(5);
        #8 check("R9", rd_data, 0); check("R9", zero_flag, 0);
        buf_en = 0; bus_write(16'd0); step(3);
        latch_en = 1; buf_en = 1; bus_write(16'd6); step(10);
        periodic_mode = 1; bus_write(16'd0); step(3);
        finish_run();
    end
endmodule